// File: doc/BRIEF.md
# Countdown Alarm with Interrupt

This block counts a programmed delay down to zero and then raises an interrupt. Software writes the delay as a packed value of days, hours, minutes and seconds, sets the run bit, and the block subtracts one second on every pulse of an external once-per-second strobe. When the subtraction that leaves the counter at zero happens, a sticky pending flag is set. The interrupt output is the pending flag gated by an interrupt-enable bit. Software clears the flag by writing a one to it.

The counter is a mixed-radix value rather than a flat binary count. Seconds and minutes wrap from 0 to 59, and hours wrap from 0 to 23, each time they borrow from the next field. Reading the delay register returns the live remaining time in the same packed layout. Generating the second strobe and turning an absolute date into a delay are done outside the block.

Top module: `gap_alarm`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Address 0x0C holds the delay: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days (0..255) in bits 28:21. A write loads the counter, and a read returns the remaining time in the same layout. Bits outside these fields read zero.
- R3: On a cycle with `tick` high, run set and a nonzero counter, the counter loses exactly one second. A zero seconds field becomes 59 and borrows from minutes. A zero minutes field becomes 59 and borrows from hours. A zero hours field becomes 23 and borrows from days.
- R4: On a cycle with `tick` low, the counter keeps its value.
- R5: Bit 8 of address 0x14 is the run bit and reads back. While it is clear, ticks leave the counter unchanged.
- R6: The tick that takes the counter from one second to zero sets the pending flag. After that the counter stays at zero and further ticks do not set the flag again.
- R7: Bit 0 of address 0x1C reads the pending flag. Writing 1 to it clears the flag. Writing 0 to it has no effect.
- R8: If the flag is set and cleared in the same cycle, it ends up set.
- R9: Bit 0 of address 0x18 is the interrupt enable and reads back. `irq` is high exactly when the flag and the enable are both set.
- R10: A delay write in the same cycle as a tick loads the written value, and that cycle does not decrement the counter or set the flag.
- R11: Reads of any other address return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Once-per-second strobe, one cycle wide |
| bus_we | input | 1 | Write strobe for `bus_addr` |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that the bus and `tick` are driven synchronously. They also assume that the counter fields only ever hold values inside their radix: seconds and minutes 0..59, hours 0..23. The decrement behaves as a clock subtraction only under that condition. The stimulus only writes delays built from in-range fields, and it only raises `tick` between clock edges. This keeps the reference model, which counts total seconds, valid for comparison on every cycle.

// File: rtl/gap_alarm.sv
module gap_alarm #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int DAY_W   = 8,
  parameter int SEC_TOP = 59,
  parameter int MIN_TOP = 59,
  parameter int HR_TOP  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_GAP = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_RUN = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'('h1C);
  localparam int S_LSB = 0, M_LSB = 8, H_LSB = 16, D_LSB = 21, RUN_BIT = 8;

  logic [5:0]       sec, min, sec_d, min_d;
  logic [4:0]       hr, hr_d;
  logic [DAY_W-1:0] day, day_d;
  logic             run, ien, pend;

  wire wr_gap   = bus_we && bus_addr == A_GAP;
  wire wr_run   = bus_we && bus_addr == A_RUN;
  wire wr_ien   = bus_we && bus_addr == A_IEN;
  wire wr_sta   = bus_we && bus_addr == A_STA;
  wire count_nz = |{sec, min, hr, day};
  wire last_sec = sec == 6'd1 && min == '0 && hr == '0 && day == '0;
  wire step     = tick && run && count_nz && !wr_gap;
  wire expire   = step && last_sec;
  wire clr      = wr_sta && bus_wdata[0];

  always_comb begin
    sec_d = sec;
    min_d = min;
    hr_d  = hr;
    day_d = day;
    if (sec != '0) sec_d = sec - 6'd1;
    else begin
      sec_d = 6'(SEC_TOP);
      if (min != '0) min_d = min - 6'd1;
      else begin
        min_d = 6'(MIN_TOP);
        if (hr != '0) hr_d = hr - 5'd1;
        else begin
          hr_d  = 5'(HR_TOP);
          day_d = day - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hr   <= '0;
      day  <= '0;
      run  <= 1'b0;
      ien  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (wr_gap) begin
        sec <= bus_wdata[S_LSB +: 6];
        min <= bus_wdata[M_LSB +: 6];
        hr  <= bus_wdata[H_LSB +: 5];
        day <= bus_wdata[D_LSB +: DAY_W];
      end else if (step) begin
        sec <= sec_d;
        min <= min_d;
        hr  <= hr_d;
        day <= day_d;
      end
      if (wr_run) run <= bus_wdata[RUN_BIT];
      if (wr_ien) ien <= bus_wdata[0];
      pend <= expire | (pend & ~clr);
    end
  end

  assign irq = pend & ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GAP: begin
        bus_rdata[S_LSB +: 6]     = sec;
        bus_rdata[M_LSB +: 6]     = min;
        bus_rdata[H_LSB +: 5]     = hr;
        bus_rdata[D_LSB +: DAY_W] = day;
      end
      A_RUN:   bus_rdata[RUN_BIT] = run;
      A_IEN:   bus_rdata[0] = ien;
      A_STA:   bus_rdata[0] = pend;
      default: bus_rdata = '0;
    endcase
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_gap |=> $stable({sec, min, hr, day})); // R4
  AST_FREEZE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_gap |=> $stable({sec, min, hr, day})); // R5
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !count_nz && !wr_gap |=> !count_nz); // R6
  AST_PEND_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(tick && run)); // R6
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tick && run && last_sec && !wr_gap && clr |=> pend); // R8
endmodule

// File: tb/gap_alarm_test.sv
module gap_alarm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  gap_alarm uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string req = "R1";
  int    m_secs = 0;
  bit    m_run = 0, m_ien = 0, m_pend = 0;

  function automatic logic [31:0] g(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] mread(logic [4:0] a);
    int r;
    r = m_secs % 86400;
    case (a)
      5'h0C:   return g(m_secs / 86400, r / 3600, (r % 3600) / 60, r % 60);
      5'h14:   return 32'(m_run) << 8;
      5'h18:   return 32'(m_ien);
      5'h1C:   return 32'(m_pend);
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(bit we, logic [4:0] a, logic [31:0] d, bit t);
    bit set;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = t;
    #1;
    checks++;
    if (bus_rdata !== mread(a)) begin
      errors++;
      $display("FAIL %s rdata@%h act %h exp %h", req, a, bus_rdata, mread(a));
    end
    checks++;
    if (irq !== (m_pend & m_ien)) begin
      errors++;
      $display("FAIL %s irq act %b exp %b", req, irq, m_pend & m_ien);
    end
    @(posedge clk);
    set = 0;
    if (we && a == 5'h0C)
      m_secs = int'(d[28:21]) * 86400 + int'(d[20:16]) * 3600 + int'(d[13:8]) * 60 + int'(d[5:0]);
    else if (t && m_run && m_secs > 0) begin
      m_secs--;
      if (m_secs == 0) set = 1;
    end
    if (we && a == 5'h14) m_run = d[8];
    if (we && a == 5'h18) m_ien = d[0];
    m_pend = set | (m_pend & !(we && a == 5'h1C && d[0]));
  endtask

  task automatic rd(logic [4:0] a, bit t = 0);
    cyc(0, a, 32'h0, t);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit t = 0);
    cyc(1, a, d, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    req = "R1";
    rd(5'h0C); rd(5'h14); rd(5'h18); rd(5'h1C);

    req = "R2";
    wr(5'h0C, g(200, 13, 45, 31) | 32'hE000_C0C0);
    rd(5'h0C);
    req = "R11";
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04); wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h0C); rd(5'h14); rd(5'h18); rd(5'h1C);

    req = "R5";
    for (int i = 0; i < 5; i++) rd(5'h0C, 1);
    wr(5'h14, 32'h100); rd(5'h14);
    req = "R4";
    for (int i = 0; i < 4; i++) rd(5'h0C, 0);

    req = "R3";
    wr(5'h0C, g(1, 0, 0, 0)); rd(5'h0C, 1); rd(5'h0C);
    wr(5'h0C, g(0, 1, 0, 0)); rd(5'h0C, 1); rd(5'h0C);
    wr(5'h0C, g(0, 0, 1, 0)); rd(5'h0C, 1); rd(5'h0C);
    wr(5'h0C, g(3, 5, 0, 0)); rd(5'h0C, 1); rd(5'h0C, 1); rd(5'h0C);

    req = "R5";
    wr(5'h14, 32'h0); rd(5'h0C, 1); rd(5'h0C, 1); rd(5'h14);
    wr(5'h14, 32'h100);

    req = "R9";
    wr(5'h18, 32'h1); rd(5'h18);
    req = "R6";
    wr(5'h0C, g(0, 0, 0, 3));
    for (int i = 0; i < 3; i++) rd(5'h1C, 1);
    for (int i = 0; i < 4; i++) rd(5'h0C, 1);
    rd(5'h1C);
    req = "R9";
    wr(5'h18, 32'h0); rd(5'h1C); wr(5'h18, 32'h1); rd(5'h1C);

    req = "R7";
    wr(5'h1C, 32'h0); rd(5'h1C);
    wr(5'h1C, 32'h1); rd(5'h1C);
    req = "R6";
    for (int i = 0; i < 3; i++) rd(5'h1C, 1);

    req = "R8";
    wr(5'h0C, g(0, 0, 0, 1));
    wr(5'h1C, 32'h1, 1); rd(5'h1C); rd(5'h0C);
    wr(5'h1C, 32'h1);

    req = "R10";
    wr(5'h0C, g(0, 0, 0, 2)); rd(5'h0C, 1);
    wr(5'h0C, g(0, 0, 2, 0), 1); rd(5'h0C);
    wr(5'h0C, g(0, 0, 0, 0), 1); rd(5'h1C);

    req = "R3";
    wr(5'h0C, g(0, 0, 2, 5));
    for (int i = 0; i < 130; i++) rd(5'h0C, 1);
    wr(5'h1C, 32'h1);

    req = "R6";
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [4:0] a;
      k = int'($urandom % 100);
      a = 5'(8'h0C + 8'(4 * ($urandom % 5)) + (($urandom % 4 == 0) ? 8'h08 : 8'h00));
      if (k < 3)       wr(5'h0C, g(int'($urandom % 3), int'($urandom % 24), int'($urandom % 60), int'($urandom % 60)), $urandom % 2 == 0);
      else if (k < 8)  wr(5'h0C, g(0, 0, 0, int'($urandom % 8)), $urandom % 2 == 0);
      else if (k < 11) wr(5'h1C, 32'($urandom % 2), $urandom % 2 == 0);
      else if (k < 13) wr(5'h14, 32'($urandom % 4 != 0) << 8, $urandom % 2 == 0);
      else if (k < 15) wr(5'h18, 32'($urandom % 2), $urandom % 2 == 0);
      else             rd(a, $urandom % 2 == 0);
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act running exp finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule